// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Sequencer

This block models, cycle by cycle, the control logic that sits behind the pins of a byte-wide parallel NOR flash. Every input is sampled on the rising edge of `clk`. A write cycle is formed from the chip-enable and write-enable strobes. A read cycle is formed from chip-enable and output-enable. Writes feed a protected command decoder. Only complete unlock sequences start an internal operation: a byte program, a sector erase or a whole-array erase.

While an internal operation runs, a busy window of a parameterised number of clock cycles stays open. During that window reads return status instead of array contents, and every write is dropped. The array is a small inferred RAM. It keeps the six sector-select address bits and the lowest `LOW_W` address bits, and aliases the bits in between. Erases walk the affected entries one per cycle inside the busy window.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A write cycle exists only while `ce_n` and `we_n` are both sampled low. The address is taken at the first edge where both are low. The data is taken at the first edge where either is high again. The command is acted on one cycle after that edge.
- R2: `dq_drive` is high in the cycle after an edge at which `ce_n` and `oe_n` are both low, and low otherwise. Whenever `dq_drive` is low, `dq_out` reads 00H.
- R3: Byte program is the sequence AAH at 5555H, 55H at 2AAAH, A0H at 5555H, followed by a data write at the target address. Command addresses are matched on address bits 14:0. The stored byte becomes the old byte ANDed with the written data.
- R4: Sector erase is the sequence AAH at 5555H, 55H at 2AAAH, 80H at 5555H, AAH at 5555H, 55H at 2AAAH, then 30H at any address. Every byte whose address bits 17:12 equal those of that last address becomes FFH. Bytes in other sectors are unchanged.
- R5: Chip erase is the same five opening cycles followed by 10H at 5555H. Every array byte becomes FFH.
- R6: A write cycle that ends while an operation is busy is ignored and leaves the decoder idle.
- R7: A wrong data value or address at any step returns the decoder to idle and starts no operation. The array is written only inside a busy window.
- R8: A read in a busy window returns status. For a program, bit 7 is the complement of bit 7 of the written data. For an erase, bit 7 is 0. Bits 5:0 are 0.
- R9: Within a busy window, bit 6 of the status is 1 on the first read and inverts on each later read start. A read start is an edge where the read condition becomes true.
- R10: Let E be the edge at which a command's final write cycle ends. A read starting at edge E+L+2 still returns status, where L is the operation's busy length in cycles. A read sampled at edge E+L+3 returns array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data written by the host |
| dq_out | output | 8 | Read data or status, 00H when not driven |
| dq_drive | output | 1 | High when the block drives the data bus |

## Verification
The bench builds the block with `LOW_W` = 2. This gives a 256-byte array with four bytes per sector, so a whole-array erase finishes its walk within a 300-cycle busy window. The program and sector erase windows are set to 12 and 20 cycles. With these short windows, the exact last status read and the first data read after a program can be placed on known edges. Writes issued inside an erase window can also be shown to be dropped.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2
  } op_kind_t;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fcsm_bus_capture.sv
module fcsm_bus_capture #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic wr_now;
  logic wr_prev;

  assign wr_now = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_prev <= wr_now;
      wr_stb  <= wr_prev && !wr_now;
      if (wr_now && !wr_prev) wr_addr <= addr;
      if (wr_prev && !wr_now) wr_data <= din;
    end
  end

endmodule

// File: rtl/fcsm_decoder.sv
module fcsm_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              busy,
  output logic              go,
  output op_kind_t          op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              idle
);

  typedef enum logic [2:0] {
    D_IDLE, D_KEY1, D_KEY2, D_PGM, D_ER1, D_ER2, D_ER3
  } dstate_t;

  dstate_t st;
  logic    hit_a;
  logic    hit_b;

  assign hit_a = (addr[14:0] == UNLOCK_A);
  assign hit_b = (addr[14:0] == UNLOCK_B);
  assign idle  = (st == D_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= D_IDLE;
      go      <= 1'b0;
      op      <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      go <= 1'b0;
      if (stb && !busy && !go) begin
        st <= D_IDLE;
        case (st)
          D_IDLE: if (data == KEY_A && hit_a) st <= D_KEY1;
          D_KEY1: if (data == KEY_B && hit_b) st <= D_KEY2;
          D_KEY2: begin
            if (hit_a && data == CMD_PROG)  st <= D_PGM;
            if (hit_a && data == CMD_ERASE) st <= D_ER1;
          end
          D_PGM: begin
            go      <= 1'b1;
            op      <= OP_PROG;
            op_addr <= addr;
            op_data <= data;
          end
          D_ER1: if (data == KEY_A && hit_a) st <= D_ER2;
          D_ER2: if (data == KEY_B && hit_b) st <= D_ER3;
          D_ER3: begin
            op_addr <= addr;
            op_data <= data;
            if (data == CMD_SECTOR) begin
              go <= 1'b1;
              op <= OP_SERASE;
            end else if (data == CMD_CHIP && hit_a) begin
              go <= 1'b1;
              op <= OP_CERASE;
            end
          end
          default: st <= D_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fcsm_array.sv
module fcsm_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fcsm_engine.sv
module fcsm_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW     = 10,
  parameter int LOW_W      = 4,
  parameter int PROG_CYC   = 1000,
  parameter int SERASE_CYC = 5000,
  parameter int CERASE_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  op_kind_t          op,
  input  logic [MEM_AW-1:0] tgt,
  input  logic [7:0]        op_data,
  input  logic              rd_start,
  input  logic [7:0]        ram_q,
  output logic              busy,
  output logic [MEM_AW-1:0] ram_raddr,
  output logic              ram_we,
  output logic [MEM_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic [7:0]        status
);

  localparam int SEC_ENT = 1 << LOW_W;
  localparam int DEPTH   = 1 << MEM_AW;
  localparam int L_PROG  = imax(PROG_CYC, 3);
  localparam int L_SE    = imax(SERASE_CYC, SEC_ENT + 1);
  localparam int L_CE    = imax(CERASE_CYC, DEPTH + 1);
  localparam int L_MAX   = imax(L_PROG, imax(L_SE, L_CE));
  localparam int CNT_W   = $clog2(L_MAX + 1);
  localparam int SEC_W   = MEM_AW - LOW_W;

  typedef enum logic [2:0] {
    E_IDLE, E_PRD, E_PWR, E_WIPE, E_WAIT
  } estate_t;

  estate_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [MEM_AW-1:0] idx;
  logic [MEM_AW-1:0] last_idx;
  logic [MEM_AW-1:0] tgt_q;
  logic [7:0]        pdata;
  logic              dq7;
  logic              tgl;

  assign busy      = (st != E_IDLE);
  assign ram_raddr = tgt_q;
  assign ram_we    = (st == E_PWR) || (st == E_WIPE);
  assign ram_waddr = (st == E_WIPE) ? idx : tgt_q;
  assign ram_wdata = (st == E_WIPE) ? 8'hFF : (ram_q & pdata);
  assign status    = {dq7, tgl, 6'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      cnt      <= '0;
      idx      <= '0;
      last_idx <= '0;
      tgt_q    <= '0;
      pdata    <= '0;
      dq7      <= 1'b0;
      tgl      <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        tgt_q <= tgt;
        pdata <= op_data;
        tgl   <= 1'b0;
        case (op)
          OP_PROG: begin
            st  <= E_PRD;
            cnt <= CNT_W'(L_PROG - 1);
            dq7 <= ~op_data[7];
          end
          OP_SERASE: begin
            st       <= E_WIPE;
            cnt      <= CNT_W'(L_SE - 1);
            dq7      <= 1'b0;
            idx      <= {tgt[MEM_AW-1 -: SEC_W], {LOW_W{1'b0}}};
            last_idx <= {tgt[MEM_AW-1 -: SEC_W], {LOW_W{1'b1}}};
          end
          default: begin
            st       <= E_WIPE;
            cnt      <= CNT_W'(L_CE - 1);
            dq7      <= 1'b0;
            idx      <= '0;
            last_idx <= '1;
          end
        endcase
      end
    end else begin
      cnt <= cnt - 1'b1;
      if (rd_start) tgl <= ~tgl;
      case (st)
        E_PRD:  st <= E_PWR;
        E_PWR:  st <= E_WAIT;
        E_WIPE: begin
          idx <= idx + 1'b1;
          if (idx == last_idx) st <= E_WAIT;
        end
        default: st <= E_WAIT;
      endcase
      if (cnt == '0) st <= E_IDLE;
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SECT_LSB   = 12,
  parameter int LOW_W      = 4,
  parameter int PROG_CYC   = 1000,
  parameter int SERASE_CYC = 5000,
  parameter int CERASE_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_drive
);

  localparam int SEC_W  = ADDR_W - SECT_LSB;
  localparam int MEM_AW = SEC_W + LOW_W;

  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              dec_go;
  op_kind_t          dec_op;
  logic [ADDR_W-1:0] dec_addr;
  logic [7:0]        dec_data;
  logic              dec_idle;
  logic              eng_busy;
  logic [MEM_AW-1:0] eng_raddr;
  logic              ram_we;
  logic [MEM_AW-1:0] ram_waddr;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_q;
  logic [7:0]        status;
  logic [MEM_AW-1:0] host_idx;
  logic [MEM_AW-1:0] op_idx;
  logic              rd_now;
  logic              rd_prev;
  logic              rd_start;
  logic              stat_sel;
  logic              unused_addr_bits;

  assign host_idx = {addr[ADDR_W-1:SECT_LSB], addr[LOW_W-1:0]};
  assign op_idx   = {dec_addr[ADDR_W-1:SECT_LSB], dec_addr[LOW_W-1:0]};
  assign unused_addr_bits = ^{addr[SECT_LSB-1:LOW_W], dec_addr[SECT_LSB-1:LOW_W]};

  assign rd_now   = !ce_n && !oe_n;
  assign rd_start = rd_now && !rd_prev;

  fcsm_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(dq_in),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcsm_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .stb(wr_stb), .addr(wr_addr), .data(wr_data),
    .busy(eng_busy), .go(dec_go), .op(dec_op), .op_addr(dec_addr),
    .op_data(dec_data), .idle(dec_idle)
  );

  fcsm_engine #(
    .MEM_AW(MEM_AW), .LOW_W(LOW_W), .PROG_CYC(PROG_CYC),
    .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) u_eng (
    .clk(clk), .rst(rst), .go(dec_go), .op(dec_op), .tgt(op_idx),
    .op_data(dec_data), .rd_start(rd_start), .ram_q(ram_q), .busy(eng_busy),
    .ram_raddr(eng_raddr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .status(status)
  );

  fcsm_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(eng_busy ? eng_raddr : host_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev  <= 1'b0;
      dq_drive <= 1'b0;
      stat_sel <= 1'b0;
    end else begin
      rd_prev  <= rd_now;
      dq_drive <= rd_now;
      stat_sel <= eng_busy;
    end
  end

  assign dq_out = !dq_drive ? 8'h00 : (stat_sel ? status : ram_q);

endmodule

// File: rtl/fcsm_checker.sv
module fcsm_checker (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic dq_drive,
  input logic busy,
  input logic wr_stb,
  input logic go,
  input logic dec_idle,
  input logic ram_we
);

  assert_read_off_R2: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> !dq_drive);

  assert_read_on_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n) |=> dq_drive);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_stb) |=> !go);

  assert_busy_idle_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> dec_idle);

  assert_write_window_R7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  assert_start_R10: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);

endmodule

bind flash_cmd_fsm fcsm_checker u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .dq_drive(dq_drive),
  .busy(eng_busy), .wr_stb(wr_stb), .go(dec_go), .dec_idle(dec_idle),
  .ram_we(ram_we)
);

// File: tb/tb_flash_cmd_fsm.sv
`timescale 1ns/1ps
module tb_flash_cmd_fsm;

  localparam int AW = 18;
  localparam int LP = 12;
  localparam int LS = 20;
  localparam int LC = 300;

  logic          clk = 1'b0;
  logic          rst;
  logic          ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [7:0]    dq_in;
  logic [7:0]    dq_out;
  logic          dq_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  flash_cmd_fsm #(
    .ADDR_W(AW), .SECT_LSB(12), .LOW_W(2),
    .PROG_CYC(LP), .SERASE_CYC(LS), .CERASE_CYC(LC)
  ) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // all tasks are entered just after a falling clock edge
  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    dq_in = 8'h00;
  endtask

  task automatic ce_write(input logic [AW-1:0] a, input logic [7:0] d);
    we_n = 1'b0; addr = ~a; dq_in = ~d;
    @(negedge clk); ce_n = 1'b0; addr = a;
    @(negedge clk); addr = ~a; dq_in = d;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1; dq_in = ~d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock;
    bus_write(18'h05555, 8'hAA);
    bus_write(18'h02AAA, 8'h55);
  endtask

  task automatic cmd_prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock; bus_write(18'h05555, 8'hA0); bus_write(a, d);
  endtask

  task automatic erase_head;
    unlock; bus_write(18'h05555, 8'h80); unlock;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset drive", {7'b0, dq_drive}, 8'h00);
    chk("R2 reset data", dq_out, 8'h00);
  endtask

  task automatic t_chip_erase;
    logic [7:0] v;
    erase_head; bus_write(18'h05555, 8'h10);
    settle(2);
    rd(18'h00000, v); chk("R8 R9 erase status first", v, 8'h40);
    rd(18'h00000, v); chk("R9 erase status second", v, 8'h00);
    rd(18'h00000, v); chk("R9 erase status third", v, 8'h40);
    settle(LC + 10);
    rd(18'h00000, v); chk("R5 erased low", v, 8'hFF);
    rd(18'h3F003, v); chk("R5 erased high", v, 8'hFF);
    rd(18'h21002, v); chk("R5 erased mid", v, 8'hFF);
  endtask

  task automatic t_program;
    logic [7:0] v;
    cmd_prog(18'h01003, 8'h5A);
    settle(2);
    rd(18'h01003, v); chk("R8 program status bit7", v, 8'hC0);
    settle(LP + 5);
    rd(18'h01003, v); chk("R3 program value", v, 8'h5A);
    cmd_prog(18'h01003, 8'hF0);
    settle(LP + 5);
    rd(18'h01003, v); chk("R3 program ANDs old byte", v, 8'h50);
  endtask

  task automatic t_busy_timing;
    logic [7:0] v;
    cmd_prog(18'h02001, 8'hC3);
    settle(LP + 1);
    addr = 18'h02001; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = dq_out;
    chk("R10 last status read", v, 8'h40);
    @(negedge clk); v = dq_out;
    chk("R10 first data read", v, 8'hC3);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    erase_head; bus_write(18'h05555, 8'h10);
    cmd_prog(18'h03002, 8'h00);
    settle(LC + 10);
    rd(18'h03002, v); chk("R6 program during busy dropped", v, 8'hFF);
    rd(18'h01003, v); chk("R6 erase still applied", v, 8'hFF);
  endtask

  task automatic t_bad_seq;
    logic [7:0] v;
    cmd_prog(18'h04001, 8'h3C);
    settle(LP + 5);
    bus_write(18'h05555, 8'hAA); bus_write(18'h02AAB, 8'h55);
    bus_write(18'h05555, 8'hA0); bus_write(18'h04002, 8'h00);
    settle(LP + 5);
    rd(18'h04002, v); chk("R7 bad address step", v, 8'hFF);
    bus_write(18'h05555, 8'hAA); bus_write(18'h02AAA, 8'h54);
    bus_write(18'h05555, 8'hA0); bus_write(18'h04002, 8'h00);
    settle(LP + 5);
    rd(18'h04002, v); chk("R7 bad data step", v, 8'hFF);
    erase_head; bus_write(18'h04000, 8'h20);
    settle(LS + 5);
    rd(18'h04001, v); chk("R7 bad erase command", v, 8'h3C);
    erase_head; bus_write(18'h04000, 8'h10);
    settle(LC + 5);
    rd(18'h04001, v); chk("R7 chip erase off 5555H", v, 8'h3C);
  endtask

  task automatic t_sector;
    logic [7:0] v;
    cmd_prog(18'h05001, 8'h11); settle(LP + 5);
    cmd_prog(18'h05002, 8'h33); settle(LP + 5);
    erase_head; bus_write(18'h05ABC, 8'h30);
    settle(2);
    rd(18'h05001, v); chk("R8 sector erase status", v, 8'h40);
    settle(LS + 5);
    rd(18'h05001, v); chk("R4 sector byte 1", v, 8'hFF);
    rd(18'h05002, v); chk("R4 sector byte 2", v, 8'hFF);
    rd(18'h04001, v); chk("R4 other sector kept", v, 8'h3C);
  endtask

  task automatic t_ce_write;
    logic [7:0] v;
    ce_write(18'h05555, 8'hAA);
    ce_write(18'h02AAA, 8'h55);
    ce_write(18'h05555, 8'hA0);
    ce_write(18'h06002, 8'h96);
    settle(LP + 5);
    rd(18'h06002, v); chk("R1 composite strobe program", v, 8'h96);
  endtask

  task automatic t_read_gate;
    addr = 18'h01003; ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R2 oe only drive", {7'b0, dq_drive}, 8'h00);
    chk("R2 oe only data", dq_out, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R2 ce only drive", {7'b0, dq_drive}, 8'h00);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_chip_erase;
    t_program;
    t_busy_timing;
    t_ignore;
    t_bad_seq;
    t_sector;
    t_ce_write;
    t_read_gate;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule